// File: doc/BRIEF.md
# Register-Mapped SPI Master

This block is a single-character SPI master that software drives through six 32-bit registers on a simple write/read port. One write to the transmit-data register shifts out one character of 1 to 16 bits on `mosi`, while `miso` is shifted in. Chip selects are not part of the block; they are expected on separate general-purpose outputs. The mode register holds the character length, bit order, serial clock idle level and phase, internal loopback, and the serial clock rate.

The serial clock is the system clock divided by an optional prescaler of 16 and then by 4×(divider+1). When a character finishes, the received bits appear right-aligned in the receive-data register and two event flags are raised: receive-not-empty and transmit-not-full. Software clears each flag by writing a one to it. A per-flag mask combines the flags into one interrupt line.

A typical transfer loop clears all events, writes a character, polls or waits for the interrupt until receive-not-empty is set, reads the received character, and repeats. The rate fields are locked while the block is enabled, so software clears the enable bit, changes the rate, then enables again.

Top module: `spi_regmaster`

## Requirements
- R1: After reset every register reads zero, `sclk` is low and `irq` is low.
- R2: Word addresses are mode=0, event=1, mask=2, command=3, transmit=4, receive=5. Mode keeps only bits 30:16, mask keeps only bits 9:8, and command keeps all 32 bits. The command register has no effect.
- R3: A transmit write starts a character only when mode bit 24 (enable) and bit 25 (master) are both set and no character is in progress. Any other transmit write causes no `sclk` edge and no event.
- R4: A character is mode bits 23:20 plus one bits long, taken from the low bits of the transmit word. With mode bit 26 set the highest of those bits goes out first; with it clear bit 0 goes out first.
- R5: Mode bit 29 sets the idle level of `sclk`. With mode bit 28 clear, data is sampled on the first (leading) edge of each bit and changed on the trailing edge. With it set, data changes on the leading edge and is sampled on the trailing edge.
- R6: Consecutive `sclk` edges are (16 if mode bit 27 else 1)×2×(PM+1) system clocks apart, where PM is mode bits 19:16.
- R7: When a character completes, the receive register holds the received bits right-aligned with the upper bits zero. Event bits 9 (receive-not-empty) and 8 (transmit-not-full) are then both set.
- R8: Writing a one to an event bit clears that bit; writing zero leaves it unchanged.
- R9: `irq` is high exactly when some event bit is set together with the mask bit at the same position.
- R10: With mode bit 30 set, the receiver takes its input from the block's own `mosi`; otherwise it takes `miso`.
- R11: A mode write while bit 24 is currently set leaves bit 27 and bits 19:16 unchanged. The other mode bits take the written value.
- R12: Clearing the enable bit during a character stops it: `sclk` returns to its idle level and no event is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register word address for read and write |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for `bus_addr` |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| irq | output | 1 | Masked event interrupt |

## Verification
The hardest situation to reach from the ports is the enable bit dropping partway through a character. The serial clock has to be in its non-idle half so that the return to idle can be seen. The bench selects the slowest rate (prescaler and divider at maximum), starts a 16-bit character, and waits until just past the first serial clock edge. It checks that `sclk` sits away from idle, then writes the mode with enable cleared. It waits longer than a full character and then checks that no flag was raised. The rate lock is reached the same way: a mode write is issued while enable is still set, and the read-back must keep the old rate fields.

// File: rtl/spi_regmaster_pkg.sv
package spi_regmaster_pkg;

  localparam int unsigned REG_W  = 32;
  localparam int unsigned ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    RA_MODE  = 3'd0,
    RA_EVENT = 3'd1,
    RA_MASK  = 3'd2,
    RA_CMD   = 3'd3,
    RA_TXD   = 3'd4,
    RA_RXD   = 3'd5
  } reg_addr_e;

  // mode register bit positions (LSB = bit 0)
  localparam int unsigned MB_LOOP  = 30;
  localparam int unsigned MB_CINV  = 29;
  localparam int unsigned MB_CPHA  = 28;
  localparam int unsigned MB_DIV16 = 27;
  localparam int unsigned MB_MSBF  = 26;
  localparam int unsigned MB_MSTR  = 25;
  localparam int unsigned MB_EN    = 24;
  localparam int unsigned MF_LEN   = 20;
  localparam int unsigned MF_PM    = 16;

  // event / mask bit positions
  localparam int unsigned EB_RXNE = 9;
  localparam int unsigned EB_TXNF = 8;

endpackage

// File: rtl/spi_rm_regs.sv
module spi_rm_regs
  import spi_regmaster_pkg::*;
#(
  parameter int unsigned LEN_W  = 4,
  parameter int unsigned PM_W   = 4,
  localparam int unsigned CHAR_W = 2 ** LEN_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  input  logic              char_done,
  input  logic [CHAR_W-1:0] rx_word,
  output logic [REG_W-1:0]  mode_q,
  output logic [1:0]        ev_q,
  output logic [1:0]        mask_q,
  output logic [REG_W-1:0]  rdata,
  output logic              irq
);

  localparam logic [REG_W-1:0] MODE_WMASK =
    (REG_W'(1) << (MB_LOOP + 1)) - (REG_W'(1) << MF_PM);
  localparam logic [REG_W-1:0] RATE_MASK =
    (REG_W'(1) << MB_DIV16) | (((REG_W'(1) << PM_W) - REG_W'(1)) << MF_PM);

  logic [REG_W-1:0] mode_nx;
  logic [REG_W-1:0] cmd_q, cmd_nx;
  logic [1:0]       ev_nx, mask_nx, w1c;
  logic             mode_ce, ev_ce, mask_ce, cmd_ce;

  // next-state
  always_comb begin
    mode_ce = wr_en && (addr == RA_MODE);
    mask_ce = wr_en && (addr == RA_MASK);
    cmd_ce  = wr_en && (addr == RA_CMD);
    w1c     = (wr_en && (addr == RA_EVENT)) ? {wdata[EB_RXNE], wdata[EB_TXNF]} : 2'b00;
    ev_ce   = char_done || (w1c != 2'b00);

    mode_nx = wdata & MODE_WMASK;
    if (mode_q[MB_EN]) begin
      // rate fields are frozen while enabled
      mode_nx = (mode_nx & ~RATE_MASK) | (mode_q & RATE_MASK);
    end

    ev_nx   = (ev_q & ~w1c) | {char_done, char_done};
    mask_nx = {wdata[EB_RXNE], wdata[EB_TXNF]};
    cmd_nx  = wdata;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      ev_q   <= '0;
      mask_q <= '0;
      cmd_q  <= '0;
    end else begin
      if (mode_ce) mode_q <= mode_nx;
      if (ev_ce)   ev_q   <= ev_nx;
      if (mask_ce) mask_q <= mask_nx;
      if (cmd_ce)  cmd_q  <= cmd_nx;
    end
  end

  // read mux
  always_comb begin
    rdata = '0;
    case (addr)
      RA_MODE:  rdata = mode_q;
      RA_EVENT: begin
        rdata[EB_RXNE] = ev_q[1];
        rdata[EB_TXNF] = ev_q[0];
      end
      RA_MASK: begin
        rdata[EB_RXNE] = mask_q[1];
        rdata[EB_TXNF] = mask_q[0];
      end
      RA_CMD:   rdata = cmd_q;
      RA_RXD:   rdata = REG_W'(rx_word);
      default:  rdata = '0;
    endcase
  end

  assign irq = |(ev_q & mask_q);

endmodule

// File: rtl/spi_rm_clkdiv.sv
module spi_rm_clkdiv #(
  parameter int unsigned PM_W     = 4,
  parameter int unsigned PRESCALE = 16,
  localparam int unsigned CNT_W   = $clog2(PRESCALE * 2 * (2 ** PM_W))
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic            div16,
  input  logic [PM_W-1:0] pm,
  output logic            tick
);

  logic [CNT_W-1:0] cnt_q, cnt_nx, half_m1;
  int               half_i;

  always_comb begin
    half_i  = (div16 ? int'(PRESCALE) : 1) * 2 * (int'(pm) + 1) - 1;
    half_m1 = CNT_W'(half_i);
    tick    = run && (cnt_q == half_m1);
    cnt_nx  = (!run || tick) ? '0 : cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_nx;
  end

endmodule

// File: rtl/spi_rm_shift.sv
module spi_rm_shift #(
  parameter int unsigned LEN_W  = 4,
  localparam int unsigned CHAR_W = 2 ** LEN_W,
  localparam int unsigned EDGE_W = LEN_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CHAR_W-1:0] tx_in,
  input  logic [LEN_W-1:0]  len,
  input  logic              en,
  input  logic              cinv,
  input  logic              cpha,
  input  logic              msbf,
  input  logic              loop,
  input  logic              tick,
  input  logic              miso,
  output logic              busy,
  output logic              sclk,
  output logic              mosi,
  output logic              done,
  output logic [CHAR_W-1:0] rx_word
);

  logic              busy_q, busy_nx;
  logic              tog_q, tog_nx;
  logic [EDGE_W-1:0] edge_q, edge_nx;
  logic [LEN_W-1:0]  bit_q, bit_nx;
  logic [CHAR_W-1:0] tx_q, acc_q, acc_nx, rx_q;
  logic [LEN_W-1:0]  len_q, idx;
  logic              msbf_q, cpha_q;
  logic              rx_in, last, step, smp, adv, acc_ce;

  always_comb begin
    idx    = msbf_q ? (len_q - bit_q) : bit_q;
    mosi   = tx_q[idx];
    rx_in  = loop ? mosi : miso;
    last   = (edge_q == {len_q, 1'b1});
    step   = busy_q && en && tick;
    smp    = step && (edge_q[0] == cpha_q);
    adv    = step && (edge_q[0] != cpha_q) && (edge_q != '0) && !last;
    done   = step && last;

    acc_nx = acc_q;
    if (smp) acc_nx[idx] = rx_in;
    if (start) acc_nx = '0;
    acc_ce = start || smp;

    busy_nx = busy_q;
    tog_nx  = tog_q;
    edge_nx = edge_q;
    bit_nx  = bit_q;
    if (start) begin
      busy_nx = 1'b1;
      tog_nx  = 1'b0;
      edge_nx = '0;
      bit_nx  = '0;
    end else if (busy_q && !en) begin
      busy_nx = 1'b0;
      tog_nx  = 1'b0;
    end else if (step) begin
      tog_nx  = ~tog_q;
      edge_nx = edge_q + EDGE_W'(1);
      if (adv)  bit_nx  = bit_q + LEN_W'(1);
      if (last) busy_nx = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      tog_q  <= 1'b0;
      edge_q <= '0;
      bit_q  <= '0;
      tx_q   <= '0;
      acc_q  <= '0;
      rx_q   <= '0;
      len_q  <= '0;
      msbf_q <= 1'b0;
      cpha_q <= 1'b0;
    end else begin
      busy_q <= busy_nx;
      tog_q  <= tog_nx;
      edge_q <= edge_nx;
      bit_q  <= bit_nx;
      if (start) begin
        tx_q   <= tx_in;
        len_q  <= len;
        msbf_q <= msbf;
        cpha_q <= cpha;
      end
      if (acc_ce) acc_q <= acc_nx;
      if (done)   rx_q  <= acc_nx;
    end
  end

  assign busy    = busy_q;
  assign sclk    = cinv ^ tog_q;
  assign rx_word = rx_q;

endmodule

// File: rtl/spi_regmaster.sv
module spi_regmaster
  import spi_regmaster_pkg::*;
#(
  parameter int unsigned LEN_W    = 4,
  parameter int unsigned PM_W     = 4,
  parameter int unsigned PRESCALE = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic [2:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        sclk,
  output logic        mosi,
  input  logic        miso,
  output logic        irq
);

  localparam int unsigned CHAR_W = 2 ** LEN_W;

  logic [REG_W-1:0]  mode_q;
  logic [1:0]        ev_q, mask_q;
  logic [CHAR_W-1:0] rx_word;
  logic              xfer_busy, char_done, tick, tx_go;
  logic              mode_unused;

  assign tx_go = bus_wr && (bus_addr == RA_TXD) && !xfer_busy &&
                 mode_q[MB_EN] && mode_q[MB_MSTR];

  assign mode_unused = ^{mode_q[REG_W-1], mode_q[MF_PM-1:0]};

  spi_rm_regs #(.LEN_W(LEN_W), .PM_W(PM_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (bus_wr),
    .addr      (bus_addr),
    .wdata     (bus_wdata),
    .char_done (char_done),
    .rx_word   (rx_word),
    .mode_q    (mode_q),
    .ev_q      (ev_q),
    .mask_q    (mask_q),
    .rdata     (bus_rdata),
    .irq       (irq)
  );

  spi_rm_clkdiv #(.PM_W(PM_W), .PRESCALE(PRESCALE)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (xfer_busy && mode_q[MB_EN]),
    .div16 (mode_q[MB_DIV16]),
    .pm    (mode_q[MF_PM +: PM_W]),
    .tick  (tick)
  );

  spi_rm_shift #(.LEN_W(LEN_W)) u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (tx_go),
    .tx_in   (bus_wdata[CHAR_W-1:0]),
    .len     (mode_q[MF_LEN +: LEN_W]),
    .en      (mode_q[MB_EN]),
    .cinv    (mode_q[MB_CINV]),
    .cpha    (mode_q[MB_CPHA]),
    .msbf    (mode_q[MB_MSBF]),
    .loop    (mode_q[MB_LOOP]),
    .tick    (tick),
    .miso    (miso),
    .busy    (xfer_busy),
    .sclk    (sclk),
    .mosi    (mosi),
    .done    (char_done),
    .rx_word (rx_word)
  );

endmodule

// File: rtl/spi_regmaster_chk.sv
module spi_regmaster_chk
  import spi_regmaster_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             bus_wr,
  input logic [2:0]       bus_addr,
  input logic [31:0]      bus_wdata,
  input logic             sclk,
  input logic [REG_W-1:0] mode_q,
  input logic [1:0]       ev_q,
  input logic             xfer_busy,
  input logic             char_done
);

  p_idle_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer_busy |-> (sclk == mode_q[MB_CINV]));

  p_tx_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == RA_TXD && !xfer_busy && !(mode_q[MB_EN] && mode_q[MB_MSTR]))
    |=> !xfer_busy);

  p_done_flags_r7: assert property (@(posedge clk) disable iff (!rst_n)
    char_done |=> (ev_q == 2'b11));

  p_w1c_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == RA_EVENT && bus_wdata[EB_RXNE] && !char_done) |=> !ev_q[1]);

  p_rate_lock_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == RA_MODE && mode_q[MB_EN])
    |=> ($stable(mode_q[MB_DIV16]) && $stable(mode_q[MF_PM +: 4])));

  p_abort_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_busy && !mode_q[MB_EN]) |=> !xfer_busy);

endmodule

bind spi_regmaster spi_regmaster_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .sclk      (sclk),
  .mode_q    (mode_q),
  .ev_q      (ev_q),
  .xfer_busy (xfer_busy),
  .char_done (char_done)
);

// File: tb/spi_regmaster_test.sv
module spi_regmaster_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr;
  logic [2:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        sclk, mosi, miso, irq;

  always #10 clk = ~clk;

  spi_regmaster uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sclk(sclk),
    .mosi(mosi), .miso(miso), .irq(irq)
  );

  int checks = 0;
  int errors = 0;

  // expected serial settings, set by the driver
  int   exp_n = 8, exp_half = 2;
  bit   exp_ci = 0, exp_cp = 0, exp_rev = 0;
  logic [15:0] exp_q[$];

  // monitor state
  bit   mon_arm = 0;
  int   mon_bits = 0, mon_edges = 0, gap = 0, edges_total = 0;
  bit   spacing_bad = 0;
  logic prev_s;
  logic got_bits [16];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  function automatic logic [31:0] mk_mode(input bit lp, input bit ci, input bit cp, input bit d16,
                                          input bit rev, input bit ms, input bit en,
                                          input int len, input int pm);
    logic [31:0] m;
    m = '0;
    m[30] = lp; m[29] = ci; m[28] = cp; m[27] = d16;
    m[26] = rev; m[25] = ms; m[24] = en;
    m[23:20] = 4'(len); m[19:16] = 4'(pm);
    return m;
  endfunction

  function automatic logic [15:0] len_mask(input int n);
    return (n >= 16) ? 16'hFFFF : 16'((32'h1 << n) - 1);
  endfunction

  // set mode in two steps so the rate fields are accepted
  task automatic configure(input bit lp, input bit ci, input bit cp, input bit d16,
                           input bit rev, input int len, input int pm);
    bus_write(3'd0, mk_mode(lp, ci, cp, d16, rev, 1, 0, len, pm));
    bus_write(3'd0, mk_mode(lp, ci, cp, d16, rev, 1, 1, len, pm));
    exp_n = len + 1; exp_ci = ci; exp_cp = cp; exp_rev = rev;
    exp_half = (d16 ? 16 : 1) * 2 * (pm + 1);
    repeat (2) @(negedge clk);
  endtask

  // driver: queue expected mosi stream, start a character, wait for RXNE
  task automatic send(input logic [15:0] tx, input logic [15:0] exp_rx, input string req);
    logic [31:0] v;
    bit seen;
    exp_q.push_back(tx & len_mask(exp_n));
    mon_bits = 0; mon_edges = 0; spacing_bad = 0; mon_arm = 1;
    bus_write(3'd4, {16'h0, tx});
    seen = 0;
    for (int i = 0; i < 5000; i++) begin
      bus_read(3'd1, v);
      if (v[9]) begin seen = 1; break; end
    end
    chk(seen, {req, " R7 rxne set"}, v, 32'h200);
    bus_read(3'd5, v);
    chk(v == {16'h0, exp_rx}, {req, " R7 rx data"}, v, {16'h0, exp_rx});
    bus_read(3'd1, v);
    chk(v == 32'h300, {req, " R7 both flags"}, v, 32'h300);
  endtask

  // monitor: watch sclk, sample mosi on sampling edges, compare to queue
  initial begin
    prev_s = 1'b0;
    forever begin
      @(negedge clk);
      gap = gap + 1;
      if (rst_n && (sclk !== prev_s)) begin
        edges_total++;
        if (mon_arm) begin
          bit lead;
          lead = (prev_s == exp_ci);
          if (mon_edges > 0 && gap != exp_half) spacing_bad = 1;
          mon_edges++;
          if ((lead != exp_cp) && mon_bits < 16) begin
            got_bits[mon_bits] = mosi;
            mon_bits++;
          end
          if (mon_edges == 2 * exp_n) begin
            logic [15:0] val, e;
            val = '0;
            for (int i = 0; i < mon_bits; i++) begin
              if (exp_rev) val = {val[14:0], got_bits[i]};
              else         val[i] = got_bits[i];
            end
            if (exp_q.size() == 0) begin
              chk(0, "R3 unexpected character", {16'h0, val}, 32'h0);
            end else begin
              e = exp_q.pop_front();
              chk(val == e, "R4 R5 serial stream", {16'h0, val}, {16'h0, e});
            end
            chk(!spacing_bad, "R6 edge spacing", 32'(gap), 32'(exp_half));
            mon_arm = 0;
          end
        end
        gap = 0;
      end
      prev_s = sclk;
    end
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v, m0;
    int e0;
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0; miso = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 6; a++) begin
      bus_read(3'(a), v);
      chk(v == 32'h0, "R1 register reset", v, 32'h0);
    end
    chk(sclk == 1'b0, "R1 sclk reset", {31'h0, sclk}, 32'h0);
    chk(irq == 1'b0, "R1 irq reset", {31'h0, irq}, 32'h0);

    // R2 read-back widths
    bus_write(3'd2, 32'hFFFF_FFFF);
    bus_read(3'd2, v);
    chk(v == 32'h300, "R2 mask readback", v, 32'h300);
    bus_write(3'd3, 32'hDEAD_BEEF);
    bus_read(3'd3, v);
    chk(v == 32'hDEAD_BEEF, "R2 command readback", v, 32'hDEAD_BEEF);
    bus_write(3'd0, 32'hFFFF_FFFF);
    bus_read(3'd0, v);
    chk(v == 32'h7FFF_0000, "R2 mode readback", v, 32'h7FFF_0000);
    // R11: enable set, so rate fields stay
    bus_write(3'd0, 32'h0);
    bus_read(3'd0, v);
    chk(v == 32'h080F_0000, "R11 rate locked while enabled", v, 32'h080F_0000);
    bus_write(3'd0, 32'h0);
    bus_read(3'd0, v);
    chk(v == 32'h0, "R11 rate accepted when disabled", v, 32'h0);
    bus_write(3'd2, 32'h0);

    // R4 R10 loopback, MSB first, 8 bits, mode 0
    configure(1, 0, 0, 0, 1, 7, 0);
    send(16'h00A5, 16'h00A5, "R10 loop msb8");

    // R9 interrupt
    chk(irq == 1'b0, "R9 irq masked", {31'h0, irq}, 32'h0);
    bus_write(3'd2, 32'h300);
    #1 chk(irq == 1'b1, "R9 irq unmasked", {31'h0, irq}, 32'h1);
    // R8 clear only rxne
    bus_write(3'd1, 32'h200);
    bus_read(3'd1, v);
    chk(v == 32'h100, "R8 w1c single flag", v, 32'h100);
    chk(irq == 1'b1, "R9 irq from txnf", {31'h0, irq}, 32'h1);
    bus_write(3'd2, 32'h200);
    #1 chk(irq == 1'b0, "R9 irq txnf masked", {31'h0, irq}, 32'h0);
    bus_write(3'd1, 32'hFFFF_FFFF);
    bus_read(3'd1, v);
    chk(v == 32'h0, "R8 w1c all", v, 32'h0);
    bus_write(3'd2, 32'h0);

    // R5 R6 mode 3, LSB first, 12 bits, PM=2
    configure(1, 1, 1, 0, 0, 11, 2);
    chk(sclk == 1'b1, "R5 idle high", {31'h0, sclk}, 32'h1);
    send(16'h05C3, 16'h05C3, "R4 lsb12");
    bus_write(3'd1, 32'hFFFF_FFFF);

    // R6 prescaler, mode 2, 4 bits MSB first
    configure(1, 1, 0, 1, 1, 3, 0);
    send(16'hFFF9, 16'h0009, "R6 div16 4bit");
    bus_write(3'd1, 32'hFFFF_FFFF);

    // R10 external input
    configure(0, 0, 0, 0, 1, 7, 0);
    miso = 1'b1;
    send(16'h003C, 16'h00FF, "R10 miso high");
    bus_write(3'd1, 32'hFFFF_FFFF);
    miso = 1'b0;
    send(16'h00C3, 16'h0000, "R10 miso low");
    bus_write(3'd1, 32'hFFFF_FFFF);

    // R5 mode 1, 16 bits
    configure(1, 0, 1, 0, 1, 15, 1);
    send(16'hBEEF, 16'hBEEF, "R5 mode1 16bit");
    bus_write(3'd1, 32'hFFFF_FFFF);

    // R11 locked write while enabled: rev flips, rate stays
    bus_read(3'd0, m0);
    bus_write(3'd0, mk_mode(1, 0, 1, 1, 0, 1, 1, 15, 5));
    bus_read(3'd0, v);
    chk(v == (m0 ^ 32'h0400_0000), "R11 partial update", v, m0 ^ 32'h0400_0000);

    // R3 transmit write ignored when disabled or not master
    bus_write(3'd0, mk_mode(1, 0, 0, 0, 1, 1, 0, 7, 0));
    repeat (4) @(negedge clk);
    e0 = edges_total;
    bus_write(3'd4, 32'h55);
    repeat (200) @(negedge clk);
    bus_read(3'd1, v);
    chk(v == 32'h0 && edges_total == e0, "R3 ignored while disabled", v, 32'h0);
    bus_write(3'd0, mk_mode(1, 0, 0, 0, 1, 0, 1, 7, 0));
    repeat (4) @(negedge clk);
    e0 = edges_total;
    bus_write(3'd4, 32'h55);
    repeat (200) @(negedge clk);
    bus_read(3'd1, v);
    chk(v == 32'h0 && edges_total == e0, "R3 ignored without master", v, 32'h0);

    // R12 abort mid-character at slowest rate
    configure(1, 0, 0, 1, 1, 15, 15);
    mon_arm = 0;
    bus_write(3'd4, 32'h1234);
    repeat (700) @(negedge clk);
    chk(sclk == 1'b1, "R12 clock running", {31'h0, sclk}, 32'h1);
    bus_write(3'd0, mk_mode(1, 0, 0, 1, 1, 1, 0, 15, 15));
    repeat (3) @(negedge clk);
    chk(sclk == 1'b0, "R12 clock idle after abort", {31'h0, sclk}, 32'h0);
    repeat (17000) @(negedge clk);
    bus_read(3'd1, v);
    chk(v == 32'h0, "R12 no event after abort", v, 32'h0);

    chk(exp_q.size() == 0, "R4 all characters seen", 32'(exp_q.size()), 32'h0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule